// File: doc/BRIEF.md
# Serial Line Register Decode

This block is the bus-side address and interrupt-vector logic for a single asynchronous serial line. It compares each 16-bit byte address on the bus against a base address set by eight board straps. On a match it raises one of four register selects (receive status, receive data, transmit status, transmit data), together with a read strobe or per-byte write strobes. The serial shifter behind those registers sees only these selects and strobes.

The same block presents the line's two interrupt requests to the bus. One vector base, set by six straps, yields the receive vector; the transmit vector sits four above it. When both sides are waiting, receive wins. The vector that was granted is held steady until the bus acknowledges it. The address straps and the vector straps have opposite sense: a fitted address strap clears its address bit, and a fitted vector strap sets its vector bit.

Top module: `sline_regdec`

## Requirements
- R1: After synchronous reset, the four selects, the read strobe, both write strobes, `irq_req`, `irq_is_tx` and `irq_vec` are all zero.
- R2: An address matches when bits 15..11 are all ones and each bit 3+i (i = 0..7) equals the inverse of `addr_strap[i]`. A fitted strap (1) therefore gives a 0 in that bit. Bits 2..0 give the offset inside the 8-byte block.
- R3: On a matching access, the select bit numbered by address bits 2..1 is raised in the cycle after the access is sampled: 0 = receive status (+0), 1 = receive data (+2), 2 = transmit status (+4), 3 = transmit data (+6).
- R4: An address that does not match raises no select and no strobe.
- R5: `reg_sel` never has more than one bit set, and it is all zeros in any cycle that follows a sampled cycle with no read and no write.
- R6: A word write raises both `wr_lo` and `wr_hi`. A byte write at an even address raises only `wr_lo`, and a byte write at an odd address raises only `wr_hi`, with the select of the same register in each case. A matching read raises `rd_stb`.
- R7: The vector is bits 8..3 = `vec_strap` taken directly (a fitted strap gives 1), with bits 1..0 = 0. Bit 2 is 0 for receive and 1 for transmit, so the transmit vector is the receive vector + 4.
- R8: When no request is being presented and `rx_pend` is high, the receive request is granted in the next cycle, whatever `tx_pend` is. `tx_pend` alone grants the transmit request.
- R9: While `irq_req` is high and `irq_ack` is low, `irq_req`, `irq_is_tx` and `irq_vec` do not change. One cycle after `irq_ack` is sampled, `irq_req` is low, and a pending request may be granted again one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_rd | input | 1 | Read access this cycle |
| bus_wr | input | 1 | Write access this cycle |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| addr_strap | input | 8 | Address straps for bits 3..10, fitted = 1 |
| vec_strap | input | 6 | Vector straps for bits 3..8, fitted = 1 |
| rx_pend | input | 1 | Receive side requests an interrupt |
| tx_pend | input | 1 | Transmit side requests an interrupt |
| irq_ack | input | 1 | Bus acknowledges the presented vector |
| reg_sel | output | 4 | One-hot register select, registered |
| rd_stb | output | 1 | Read strobe, registered |
| wr_lo | output | 1 | Low byte write strobe, registered |
| wr_hi | output | 1 | High byte write strobe, registered |
| irq_req | output | 1 | Interrupt request presented |
| irq_is_tx | output | 1 | Granted request is the transmit one |
| irq_vec | output | 9 | Vector of the granted request, zero when idle |

## Verification
The bench uses the default widths: eight address straps, six vector straps and four registers. At these widths every one of the 256 address strap settings can be tried, each with all eight byte offsets and with near-miss addresses that differ in one strap bit or one fixed upper bit. All 64 vector strap settings are tried with receive alone, transmit alone and both pending at once. This makes the polarity of both strap sets, the byte-lane choice and the priority order checkable against plain arithmetic for every value.

// File: rtl/sline_regdec_pkg.sv
package sline_regdec_pkg;

    localparam int ADDR_W   = 16;
    localparam int STRAP_LO = 3;
    localparam int ASTRAP_N = 8;
    localparam int VSTRAP_N = 6;
    localparam int NREG     = 4;

    typedef enum logic [1:0] {
        REG_RX_STAT = 2'd0,
        REG_RX_DATA = 2'd1,
        REG_TX_STAT = 2'd2,
        REG_TX_DATA = 2'd3
    } reg_id_e;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              wr;
        logic              byte_acc;
    } bus_req_t;

    typedef struct packed {
        logic [NREG-1:0] sel;
        logic            rd;
        logic            wlo;
        logic            whi;
    } reg_strobe_t;

    // Fitted address strap clears its bit: the base is the inverted strap word.
    function automatic logic [ASTRAP_N-1:0] strap_to_base(input logic [ASTRAP_N-1:0] s);
        return ~s;
    endfunction

endpackage

// File: rtl/sline_addr_dec.sv
module sline_addr_dec
    import sline_regdec_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int SLO  = STRAP_LO,
    parameter int SN   = ASTRAP_N,
    parameter int NR   = NREG
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic [SN-1:0] straps,
    output reg_strobe_t   strb
);
    localparam int IDX_W  = $clog2(NR);
    localparam int FIX_LO = SLO + SN;
    localparam int FIX_N  = AW - FIX_LO;

    logic [SN-1:0]    base_bits;
    logic             upper_ok;
    logic             strap_ok;
    logic             hit;
    logic             acc;
    logic [IDX_W-1:0] idx;
    reg_strobe_t      strb_d;

    assign base_bits = strap_to_base(straps);
    assign upper_ok  = &req.addr[AW-1:FIX_LO];
    assign strap_ok  = (req.addr[FIX_LO-1:SLO] == base_bits);
    assign hit       = upper_ok && strap_ok;
    assign acc       = req.rd || req.wr;
    assign idx       = req.addr[1 +: IDX_W];

    for (genvar g = 0; g < NR; g++) begin : g_sel
        assign strb_d.sel[g] = hit && acc && (idx == IDX_W'(g));
    end

    assign strb_d.rd  = hit && req.rd;
    assign strb_d.wlo = hit && req.wr && (!req.byte_acc || !req.addr[0]);
    assign strb_d.whi = hit && req.wr && (!req.byte_acc ||  req.addr[0]);

    always_ff @(posedge clk) begin
        if (rst) strb <= '0;
        else     strb <= strb_d;
    end

    if (FIX_N < 1) begin : g_bad
        initial $error("address width leaves no fixed upper bits");
    end
endmodule

// File: rtl/sline_vec_arb.sv
module sline_vec_arb
    import sline_regdec_pkg::*;
#(
    parameter int SLO = STRAP_LO,
    parameter int VN  = VSTRAP_N,
    localparam int VW = SLO + VN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VN-1:0] straps,
    input  logic          rx_pend,
    input  logic          tx_pend,
    input  logic          ack,
    output logic          req,
    output logic          is_tx,
    output logic [VW-1:0] vec
);
    localparam logic [VW-1:0] TX_OFS = VW'(4);

    arb_state_e    state;
    logic          pick_tx;
    logic [VW-1:0] base_vec;

    assign pick_tx  = !rx_pend;
    assign base_vec = {straps, {SLO{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
            is_tx <= 1'b0;
            vec   <= '0;
        end else begin
            unique case (state)
                ARB_IDLE: begin
                    if (rx_pend || tx_pend) begin
                        state <= ARB_GRANT;
                        is_tx <= pick_tx;
                        vec   <= pick_tx ? (base_vec | TX_OFS) : base_vec;
                    end
                end
                ARB_GRANT: begin
                    if (ack) begin
                        state <= ARB_IDLE;
                        is_tx <= 1'b0;
                        vec   <= '0;
                    end
                end
                default: state <= ARB_IDLE;
            endcase
        end
    end

    assign req = (state == ARB_GRANT);
endmodule

// File: rtl/sline_regdec.sv
module sline_regdec
    import sline_regdec_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int SLO = STRAP_LO,
    parameter int ASN = ASTRAP_N,
    parameter int VSN = VSTRAP_N,
    parameter int NR  = NREG,
    localparam int VW = SLO + VSN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic           bus_byte,
    input  logic [ASN-1:0] addr_strap,
    input  logic [VSN-1:0] vec_strap,
    input  logic           rx_pend,
    input  logic           tx_pend,
    input  logic           irq_ack,
    output logic [NR-1:0]  reg_sel,
    output logic           rd_stb,
    output logic           wr_lo,
    output logic           wr_hi,
    output logic           irq_req,
    output logic           irq_is_tx,
    output logic [VW-1:0]  irq_vec
);
    bus_req_t    req;
    reg_strobe_t strb;

    assign req.addr     = bus_addr;
    assign req.rd       = bus_rd;
    assign req.wr       = bus_wr;
    assign req.byte_acc = bus_byte;

    sline_addr_dec #(.AW(AW), .SLO(SLO), .SN(ASN), .NR(NR)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .straps (addr_strap),
        .strb   (strb)
    );

    sline_vec_arb #(.SLO(SLO), .VN(VSN)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .straps  (vec_strap),
        .rx_pend (rx_pend),
        .tx_pend (tx_pend),
        .ack     (irq_ack),
        .req     (irq_req),
        .is_tx   (irq_is_tx),
        .vec     (irq_vec)
    );

    assign reg_sel = strb.sel;
    assign rd_stb  = strb.rd;
    assign wr_lo   = strb.wlo;
    assign wr_hi   = strb.whi;
endmodule

// File: rtl/sline_regdec_chk.sv
module sline_regdec_chk #(
    parameter int NR = 4,
    parameter int VW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_byte,
    input logic          rx_pend,
    input logic          irq_ack,
    input logic [NR-1:0] reg_sel,
    input logic          rd_stb,
    input logic          wr_lo,
    input logic          wr_hi,
    input logic          irq_req,
    input logic          irq_is_tx,
    input logic [VW-1:0] irq_vec
);
    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_sel));

    // R5
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !bus_wr) |=> (reg_sel == '0));

    // R4
    strobe_has_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_lo || wr_hi) |-> (reg_sel != '0));

    // R6
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_byte) |=> !(wr_lo && wr_hi));

    // R8
    rx_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && rx_pend) |=> (irq_req && !irq_is_tx));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_is_tx)));

    // R9
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req);

    // R7
    vec_low_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[1:0] == 2'b00 && irq_vec[2] == irq_is_tx));
endmodule

bind sline_regdec sline_regdec_chk #(.NR(NR), .VW(VW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_byte  (bus_byte),
    .rx_pend   (rx_pend),
    .irq_ack   (irq_ack),
    .reg_sel   (reg_sel),
    .rd_stb    (rd_stb),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .irq_req   (irq_req),
    .irq_is_tx (irq_is_tx),
    .irq_vec   (irq_vec)
);

// File: tb/tb_sline_regdec.sv
module tb_sline_regdec;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr, bus_byte;
    logic [7:0]  addr_strap;
    logic [5:0]  vec_strap;
    logic        rx_pend, tx_pend, irq_ack;
    logic [3:0]  reg_sel;
    logic        rd_stb, wr_lo, wr_hi;
    logic        irq_req, irq_is_tx;
    logic [8:0]  irq_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sline_regdec dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_byte(bus_byte), .addr_strap(addr_strap),
        .vec_strap(vec_strap), .rx_pend(rx_pend), .tx_pend(tx_pend),
        .irq_ack(irq_ack), .reg_sel(reg_sel), .rd_stb(rd_stb),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .irq_req(irq_req),
        .irq_is_tx(irq_is_tx), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One access; expected values from address arithmetic (R2, R3, R4, R6).
    task automatic access(input logic [15:0] a, input logic rd, input logic wr, input logic bt);
        logic       hit;
        logic [3:0] esel;
        logic       elo, ehi;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_byte = bt;
        hit  = (a[15:11] == 5'h1f) && (a[10:3] == ~addr_strap);
        esel = (hit && (rd || wr)) ? (4'b0001 << a[2:1]) : 4'b0000;
        elo  = hit && wr && (!bt || !a[0]);
        ehi  = hit && wr && (!bt ||  a[0]);
        tick();
        chk(hit ? "R3 sel" : "R4 sel", 32'(reg_sel), 32'(esel));
        chk("R6 rd_stb", 32'(rd_stb), 32'(hit && rd));
        chk("R6 wr lanes", {30'd0, ehi, elo} == {30'd0, wr_hi, wr_lo} ? 32'd1 : {30'd0, wr_hi, wr_lo},
            {30'd0, ehi, elo} == {30'd0, wr_hi, wr_lo} ? 32'd1 : {30'd0, ehi, elo});
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] base;
        logic [8:0]  rxv;
        rst = 1'b1; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_byte = 0;
        addr_strap = 8'h11; vec_strap = 6'h06;
        rx_pend = 0; tx_pend = 0; irq_ack = 0;
        tick(); tick();
        // R1 reset state
        chk("R1 sel", 32'(reg_sel), 0);
        chk("R1 strobes", {29'd0, rd_stb, wr_lo, wr_hi}, 0);
        chk("R1 irq", {22'd0, irq_req, irq_is_tx, irq_vec}, 0);
        rst = 1'b0;
        tick();

        // R2 example: straps 0x11 place the block at 0177560
        access(16'o177560, 1'b1, 1'b0, 1'b0);
        chk("R2 console rx status", 32'(reg_sel), 32'h1);
        access(16'o177566, 1'b0, 1'b1, 1'b0);
        chk("R2 console tx data", 32'(reg_sel), 32'h8);

        // R2 R3 R4 R6 sweep every address strap setting
        for (int s = 0; s < 256; s++) begin
            addr_strap = 8'(s);
            base = {5'h1f, ~addr_strap, 3'b000};
            for (int o = 0; o < 8; o++) begin
                access(base + 16'(o), 1'b0, 1'b1, 1'b1);
                access(base + 16'(o), 1'b1, 1'b0, 1'b0);
            end
            access(base + 16'd6, 1'b0, 1'b1, 1'b0);
            access(base ^ (16'h8 << (s % 8)), 1'b1, 1'b0, 1'b0);
            access(base ^ (16'h0800 << (s % 5)), 1'b0, 1'b1, 1'b0);
            // R5 no access: selects stay clear
            bus_addr = base; tick();
            chk("R5 idle sel", 32'(reg_sel), 0);
        end

        // R7 R8 R9 sweep every vector strap setting
        for (int v = 0; v < 64; v++) begin
            vec_strap = 6'(v);
            rxv = {vec_strap, 3'b000};
            rx_pend = 1; tick();
            chk("R7 rx vec", 32'(irq_vec), 32'(rxv));
            chk("R8 rx alone", {30'd0, irq_req, irq_is_tx}, 32'b10);
            irq_ack = 1; rx_pend = 0; tick();
            chk("R9 drop", 32'(irq_req), 0);
            irq_ack = 0;
            tx_pend = 1; tick();
            chk("R7 tx vec", 32'(irq_vec), 32'(rxv + 9'd4));
            tick(); tick();
            chk("R9 hold", {21'd0, irq_req, irq_is_tx, irq_vec}, {21'd0, 2'b11, rxv + 9'd4});
            irq_ack = 1; tx_pend = 0; tick(); irq_ack = 0;
            rx_pend = 1; tx_pend = 1; tick();
            chk("R8 both", {30'd0, irq_req, irq_is_tx}, 32'b10);
            irq_ack = 1; rx_pend = 0; tick();
            chk("R9 gap", 32'(irq_req), 0);
            irq_ack = 0; tick();
            chk("R8 tx after rx", {21'd0, irq_req, irq_is_tx, irq_vec}, {21'd0, 2'b11, rxv + 9'd4});
            irq_ack = 1; tx_pend = 0; tick(); irq_ack = 0;
        end

        // R7 example vector settings
        vec_strap = 6'o30;
        rx_pend = 1; tick();
        chk("R7 vector 0300", 32'(irq_vec), 32'o300);
        irq_ack = 1; rx_pend = 0; tick(); irq_ack = 0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule